// File: doc/BRIEF.md
# NOR Flash Single-Word Programmer

This controller writes one 16-bit word into a parallel NOR flash that uses the common unlock-command protocol. A client raises `req_valid` with a word address and a data value. The controller first reads the target word. Programming can only clear bits, so if any bit that should end up 1 is already 0, the controller gives up at once and issues no command. Otherwise it sends the two unlock writes and the program command to fixed offsets from the bank base. It then writes the data to the destination. After that it reads the destination repeatedly until bit 7 of the word read back matches bit 7 of the data.

If polling runs past a programmable cycle budget, the controller writes the reset command to the destination and reports a timeout. The result appears as a 2-bit code during a one-cycle `done` pulse. The flash side is a single-outstanding request/acknowledge bus. The controller holds address, direction and write data steady until the flash side acknowledges, and read data comes back in the same cycle as the acknowledge.

Top module: `nor_wordprog`

## Requirements
- R1: A request seen while idle is accepted. `busy` rises on the next cycle and stays high through the cycle that carries `done`. It is low on the cycle after `done`.
- R2: The first flash access of every operation is a read of the destination word.
- R3: If (word read AND data) differs from data, the operation ends with status 2 (not erased) and no flash write is issued.
- R4: Otherwise exactly these writes follow, in this order: 0x00AA to BASE+0x555, 0x0055 to BASE+0x2AA, 0x00A0 to BASE+0x555, then the data to the destination. BASE is the bank base parameter and is independent of the destination.
- R5: After the data write, the controller reads the destination back to back. When bit 7 of a read equals bit 7 of the data, the operation ends with status 0.
- R6: If bit 7 still mismatches once TIMEOUT_CYC polling cycles have passed, the controller writes 0x00F0 to the destination and the operation ends with status 1.
- R7: A request presented while `busy` is high is ignored. It produces no flash access and changes no stored word.
- R8: While `fl_req` is high and `fl_ack` is low, `fl_req`, `fl_we`, `fl_addr` and `fl_wdata` stay unchanged on the next cycle. No flash access is requested while idle.
- R9: `done` is a single-cycle pulse. The status it carries is 0 (success), 1 (timeout) or 2 (not erased), and never 3.
- R10: After reset, `busy`, `done` and `fl_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Program request strobe |
| req_addr | input | AW | Destination word address |
| req_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Status valid pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 not erased |
| fl_req | output | 1 | Flash access request |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_ack | input | 1 | Flash access completed |
| fl_rdata | input | DW | Flash read data, valid with fl_ack |

## Verification
The bench builds the controller with a 12-bit word address, a bank base of 0x800 and a 40-cycle polling budget. The high base keeps unlock addresses apart from destinations in the lower half, so a command sent relative to the destination shows up as a wrong address in the write log. The short budget lets a flash model that stays busy for 1000 cycles reach the timeout and reset path quickly. Random busy times of up to 15 cycles always finish inside the budget.

// File: rtl/nwp_pkg.sv
package nwp_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_CHECK, S_UNLOCK, S_PROG, S_POLL, S_RESET, S_DONE
   } nwp_state_e;

   localparam logic [1:0] ST_OK         = 2'd0;
   localparam logic [1:0] ST_TIMEOUT    = 2'd1;
   localparam logic [1:0] ST_NOT_ERASED = 2'd2;

   localparam int UNLOCK_STEPS = 3;
endpackage

// File: rtl/nwp_cmd_seq.sv
module nwp_cmd_seq #(
   parameter int AW = 22,
   parameter int DW = 16,
   parameter logic [AW-1:0] BASE = '0
) (
   input  logic [1:0]    step,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data
);
   localparam logic [AW-1:0] OFS_A = AW'(12'h555);
   localparam logic [AW-1:0] OFS_B = AW'(12'h2AA);

   always_comb begin
      case (step)
         2'd0:    begin cmd_addr = BASE + OFS_A; cmd_data = DW'(16'h00AA); end
         2'd1:    begin cmd_addr = BASE + OFS_B; cmd_data = DW'(16'h0055); end
         default: begin cmd_addr = BASE + OFS_A; cmd_data = DW'(16'h00A0); end
      endcase
   end
endmodule

// File: rtl/nwp_tmo.sv
module nwp_tmo #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  cnt <= '0;
      else if (en && !expired) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt >= CW'(LIMIT));
endmodule

// File: rtl/nor_wordprog.sv
module nor_wordprog #(
   parameter int AW = 22,
   parameter int DW = 16,
   parameter logic [AW-1:0] BASE = '0,
   parameter int TIMEOUT_CYC = 5000,
   parameter int POLL_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          busy,
   output logic          done,
   output logic [1:0]    status,
   output logic          fl_req,
   output logic          fl_we,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_wdata,
   input  logic          fl_ack,
   input  logic [DW-1:0] fl_rdata
);
   import nwp_pkg::*;

   localparam logic [DW-1:0] RESET_CMD = DW'(16'h00F0);

   generate
      if (AW < 12) begin : g_bad_aw
         $error("AW must cover the unlock offsets");
      end
      if (DW < 8 || POLL_BIT >= DW) begin : g_bad_dw
         $error("DW must hold command bytes and the poll bit");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_tmo
         $error("TIMEOUT_CYC must be positive");
      end
   endgenerate

   nwp_state_e    state;
   logic [1:0]    step;
   logic [AW-1:0] dest;
   logic [DW-1:0] wdata;
   logic [1:0]    status_q;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] cmd_data;
   logic          tmo_expired;

   nwp_cmd_seq #(.AW(AW), .DW(DW), .BASE(BASE)) u_cmd (
      .step(step), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   nwp_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n),
      .clr(state == S_PROG), .en(state == S_POLL),
      .expired(tmo_expired)
   );

   always_comb begin
      fl_req   = 1'b0;
      fl_we    = 1'b0;
      fl_addr  = dest;
      fl_wdata = wdata;
      case (state)
         S_CHECK:  fl_req = 1'b1;
         S_UNLOCK: begin
            fl_req = 1'b1; fl_we = 1'b1;
            fl_addr = cmd_addr; fl_wdata = cmd_data;
         end
         S_PROG:   begin fl_req = 1'b1; fl_we = 1'b1; end
         S_POLL:   fl_req = 1'b1;
         S_RESET:  begin fl_req = 1'b1; fl_we = 1'b1; fl_wdata = RESET_CMD; end
         default:  ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step     <= '0;
         dest     <= '0;
         wdata    <= '0;
         status_q <= ST_OK;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               dest  <= req_addr;
               wdata <= req_data;
               state <= S_CHECK;
            end
            S_CHECK: if (fl_ack) begin
               if ((fl_rdata & wdata) != wdata) begin
                  status_q <= ST_NOT_ERASED;
                  state    <= S_DONE;
               end else begin
                  step  <= '0;
                  state <= S_UNLOCK;
               end
            end
            S_UNLOCK: if (fl_ack) begin
               if (step == 2'(UNLOCK_STEPS - 1)) state <= S_PROG;
               step <= step + 2'd1;
            end
            S_PROG: if (fl_ack) state <= S_POLL;
            S_POLL: if (fl_ack) begin
               if (fl_rdata[POLL_BIT] == wdata[POLL_BIT]) begin
                  status_q <= ST_OK;
                  state    <= S_DONE;
               end else if (tmo_expired) begin
                  state <= S_RESET;
               end
            end
            S_RESET: if (fl_ack) begin
               status_q <= ST_TIMEOUT;
               state    <= S_DONE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy   = (state != S_IDLE);
   assign done   = (state == S_DONE);
   assign status = status_q;
endmodule

// File: rtl/nwp_checker.sv
module nwp_checker #(
   parameter int AW = 22,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          busy,
   input logic          done,
   input logic [1:0]    status,
   input logic          fl_req,
   input logic          fl_we,
   input logic [AW-1:0] fl_addr,
   input logic [DW-1:0] fl_wdata,
   input logic          fl_ack
);
   a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy |=> busy);
   a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   a_r2_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> fl_req && !fl_we);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_we) && $stable(fl_addr) && $stable(fl_wdata));
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fl_req);
   a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_code: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy && status != 2'd3);
endmodule

bind nor_wordprog nwp_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .done(done), .status(status), .fl_req(fl_req), .fl_we(fl_we),
   .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack)
);

// File: tb/nor_wordprog_tb.sv
module nor_wordprog_tb;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam logic [AW-1:0] BASE = 12'h800;
   localparam int TMO = 40;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic busy, done;
   logic [1:0] status;
   logic fl_req, fl_we;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata;
   logic fl_ack = 0;
   logic [DW-1:0] fl_rdata = '0;

   always #10 clk = ~clk;

   nor_wordprog #(.AW(AW), .DW(DW), .BASE(BASE), .TIMEOUT_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .busy(busy), .done(done), .status(status),
      .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_ack(fl_ack), .fl_rdata(fl_rdata)
   );

   // flash model
   logic [DW-1:0] mem [4096];
   logic [AW-1:0] log_a [16];
   logic [DW-1:0] log_d [16];
   int log_n = 0;
   int phase = 0, pbusy = 0, busy_len = 0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pdata = '0;

   always @(posedge clk) begin
      if (pbusy > 0) pbusy = pbusy - 1;
      fl_ack <= 1'b0;
      if (rst_n && fl_req && !fl_ack) begin
         fl_ack <= 1'b1;
         if (fl_we) begin
            if (log_n < 16) begin log_a[log_n] = fl_addr; log_d[log_n] = fl_wdata; end
            log_n = log_n + 1;
            if (phase == 3) begin
               mem[fl_addr] = mem[fl_addr] & fl_wdata;
               paddr = fl_addr; pdata = fl_wdata; pbusy = busy_len; phase = 0;
            end else if (phase == 0 && fl_addr == BASE + 12'h555 && fl_wdata == 16'h00AA) phase = 1;
            else if (phase == 1 && fl_addr == BASE + 12'h2AA && fl_wdata == 16'h0055) phase = 2;
            else if (phase == 2 && fl_addr == BASE + 12'h555 && fl_wdata == 16'h00A0) phase = 3;
            else begin phase = 0; if (fl_wdata == 16'h00F0) pbusy = 0; end
         end else if (pbusy > 0 && fl_addr == paddr)
            fl_rdata <= {mem[fl_addr][15:8], ~pdata[7], mem[fl_addr][6:0]};
         else
            fl_rdata <= mem[fl_addr];
      end
   end

   int n_checks = 0, n_fail = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_status(input logic [15:0] pre, input logic [15:0] d);
      return ((pre & d) != d) ? 2'd2 : 2'd0;
   endfunction

   logic [1:0] got_status;
   bit busy_ok;

   task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input int bl);
      int cnt;
      busy_len = bl;
      log_n = 0;
      busy_ok = 1;
      @(negedge clk);
      req_valid = 1; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 0;
      cnt = 0;
      while (!done && cnt < 3000) begin
         if (!busy) busy_ok = 0;
         @(negedge clk);
         cnt++;
      end
      if (cnt >= 3000) check(0, "watchdog", cnt, 0);
      got_status = status;
      @(negedge clk);
      check(!busy, "R1 busy drops after done", busy, 0);
   endtask

   task automatic check_prog_log(input logic [AW-1:0] a, input logic [DW-1:0] d);
      check(log_a[0] == BASE + 12'h555 && log_d[0] == 16'h00AA, "R4 first unlock", log_a[0], BASE + 12'h555);
      check(log_a[1] == BASE + 12'h2AA && log_d[1] == 16'h0055, "R4 second unlock", log_a[1], BASE + 12'h2AA);
      check(log_a[2] == BASE + 12'h555 && log_d[2] == 16'h00A0, "R4 program cmd", log_d[2], 16'h00A0);
      check(log_a[3] == a && log_d[3] == d, "R4 data write", log_d[3], d);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      check(!busy && !done && !fl_req, "R10 reset state", {busy, done, fl_req}, 0);
      rst_n = 1;
      @(negedge clk);

      // R5 directed success
      run_op(12'h123, 16'h5A3C, 6);
      check(got_status == 2'd0, "R5 status ok", got_status, 0);
      check(busy_ok, "R1 busy held", busy_ok, 1);
      check(log_n == 4, "R4 write count", log_n, 4);
      check_prog_log(12'h123, 16'h5A3C);
      check(mem[12'h123] == 16'h5A3C, "R5 word stored", mem[12'h123], 16'h5A3C);

      // R3 not erased
      mem[12'h200] = 16'hFF7F;
      run_op(12'h200, 16'h0080, 0);
      check(got_status == 2'd2, "R3 status not erased", got_status, 2);
      check(log_n == 0, "R3 no writes", log_n, 0);
      check(mem[12'h200] == 16'hFF7F, "R3 word untouched", mem[12'h200], 16'hFF7F);

      // R6 timeout
      run_op(12'h0F0, 16'h1234, 1000);
      check(got_status == 2'd1, "R6 status timeout", got_status, 1);
      check(log_n == 5, "R6 write count", log_n, 5);
      check(log_a[4] == 12'h0F0 && log_d[4] == 16'h00F0, "R6 reset write", log_d[4], 16'h00F0);

      // R7 request while busy ignored
      busy_len = 4; log_n = 0;
      @(negedge clk);
      req_valid = 1; req_addr = 12'h300; req_data = 16'h00FF;
      @(negedge clk);
      req_addr = 12'h301; req_data = 16'h0000;
      repeat (3) @(negedge clk);
      req_valid = 0;
      while (!done) @(negedge clk);
      repeat (5) @(negedge clk);
      check(log_n == 4, "R7 extra request ignored", log_n, 4);
      check(mem[12'h301] == 16'hFFFF, "R7 other word untouched", mem[12'h301], 16'hFFFF);
      check(!busy, "R7 idle afterwards", busy, 0);

      // random
      void'($urandom(32'd7));
      for (int k = 0; k < 24; k++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d, pre;
         logic [1:0] es;
         a = AW'($urandom_range(0, 12'h7FF));
         d = DW'($urandom);
         pre = ($urandom_range(0, 1) == 0) ? 16'hFFFF : DW'($urandom);
         mem[a] = pre;
         es = exp_status(pre, d);
         run_op(a, d, $urandom_range(0, 15));
         check(got_status == es, "R3/R5 random status", got_status, es);
         check(mem[a] == ((es == 0) ? d : pre), "R5 random word", mem[a], (es == 0) ? d : pre);
         check(log_n == ((es == 0) ? 4 : 0), "R4 random write count", log_n, (es == 0) ? 4 : 0);
         if (es == 0) check_prog_log(a, d);
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule